// File: doc/BRIEF.md
# Unsigned Magnitude Comparator with Selectable Merge Structure

This block compares two unsigned operands of a configurable width and reports the ordering on two wires. `gt_o` is high when the first operand is larger. `lt_o` is high when the second operand is larger. When the operands are equal, both wires stay low. There is no separate equality output. The block is purely combinational: it has no clock, no reset and no handshake, and its outputs follow its inputs within the same cycle.

The operands are split into 2-bit slices. Each slice has its own small comparison cell that produces a greater/less pair. The pairs are then combined by a join rule in which the more significant pair decides whenever it is not equal. A parameter selects how the joins are arranged:

- a linear chain running from the least significant slice upward, with delay that grows linearly in the slice count;
- a balanced binary tree, with delay that grows with the logarithm of the slice count.

An operand width that is not a multiple of two is handled by zero-extending both operands by one bit.

Top module: `mag_cmp`

## Requirements
- R1: `gt_o` is 1 exactly when `x_in` > `y_in`, with both operands read as unsigned integers.
- R2: `lt_o` is 1 exactly when `x_in` < `y_in`, with both operands read as unsigned integers.
- R3: When `x_in` equals `y_in`, both `gt_o` and `lt_o` are 0.
- R4: `gt_o` and `lt_o` are never 1 together, for any input.
- R5: When the most significant bits in which the operands differ lie in a higher slice, that slice alone sets the result. For example, 0x80 vs 0x7F gives gt=1 and 0x7F vs 0x80 gives lt=1.
- R6: When all higher slices are equal, the result follows the lower slices. For example, 0x51 vs 0x50 gives gt=1 and 0x50 vs 0x51 gives lt=1.
- R7: `USE_TREE`=0 (chain) and `USE_TREE`=1 (tree) give identical outputs for every operand pair.
- R8: An odd `WIDTH` compares correctly; the bits added by zero-extension never change the result.
- R9: The outputs settle in the same cycle as the input change, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | WIDTH | First unsigned operand |
| y_in | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when x_in > y_in |
| lt_o | output | 1 | High when x_in < y_in |

## Verification
The bench builds three instances:

- an 8-bit tree instance;
- an 8-bit chain instance;
- a 5-bit tree instance, whose odd width forces a zero-extended top slice and a tree padded to a power of two.

At these widths every operand pair can be applied. The two 8-bit structures are therefore compared against the unsigned relational operators and against each other over all 65536 pairs. The 5-bit instance is checked over all 1024 pairs, which covers the padding paths.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  typedef struct packed {
    logic gt;
    logic lt;
  } rel_t;

  // Higher-significance pair wins unless it reports equality.
  function automatic rel_t rel_join(input rel_t hi, input rel_t lo);
    rel_t r;
    r.gt = hi.gt | (~hi.gt & ~hi.lt & lo.gt);
    r.lt = hi.lt | (~hi.gt & ~hi.lt & lo.lt);
    return r;
  endfunction

endpackage

// File: rtl/mag_cmp_cell2.sv
module mag_cmp_cell2
  import mag_cmp_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  output rel_t       rel
);

  always_comb begin
    rel.gt = (a[1] & ~b[1]) | (a[0] & ~b[1] & ~b[0]) | (a[1] & a[0] & ~b[0]);
    rel.lt = (~a[1] & b[1]) | (~a[1] & ~a[0] & b[0]) | (~a[0] & b[1] & b[0]);
    assert_cell_excl_R4 : assert (!(rel.gt && rel.lt));
    if (a == b) begin
      assert_cell_eq_R3 : assert (!rel.gt && !rel.lt);
    end
  end

endmodule

// File: rtl/mag_cmp_join.sv
module mag_cmp_join
  import mag_cmp_pkg::*;
(
  input  rel_t hi,
  input  rel_t lo,
  output rel_t res
);

  always_comb begin
    res = rel_join(hi, lo);
    if (hi.gt || hi.lt) begin
      assert_join_hi_R5 : assert (res == hi);
    end else begin
      assert_join_lo_R6 : assert (res == lo);
    end
    assert_join_excl_R4 : assert (!(res.gt && res.lt) || (hi.gt && hi.lt) || (lo.gt && lo.lt));
  end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int NCELL = 4
) (
  input  rel_t [NCELL-1:0] leaf,
  output rel_t             root
);

  rel_t acc [NCELL];

  assign acc[0] = leaf[0];

  for (genvar i = 1; i < NCELL; i++) begin : g_link
    mag_cmp_join u_join (
      .hi  (leaf[i]),
      .lo  (acc[i-1]),
      .res (acc[i])
    );
  end

  assign root = acc[NCELL-1];

endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree
  import mag_cmp_pkg::*;
#(
  parameter int NCELL = 4
) (
  input  rel_t [NCELL-1:0] leaf,
  output rel_t             root
);

  localparam int LVLS  = $clog2(NCELL);
  localparam int NLEAF = 1 << LVLS;
  localparam int NNODE = 2 * NLEAF - 1;

  // Heap layout: node k has children 2k+1 (less significant) and 2k+2.
  rel_t node [NNODE];

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    if (i < NCELL) begin : g_real
      assign node[NLEAF-1+i] = leaf[i];
    end else begin : g_pad
      assign node[NLEAF-1+i] = '0;
    end
  end

  for (genvar k = 0; k < NLEAF - 1; k++) begin : g_node
    mag_cmp_join u_join (
      .hi  (node[2*k+2]),
      .lo  (node[2*k+1]),
      .res (node[k])
    );
  end

  assign root = node[0];

endmodule

// File: rtl/mag_cmp.sv
module mag_cmp
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit USE_TREE = 1'b1
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic             gt_o,
  output logic             lt_o
);

  localparam int NCELL = (WIDTH + 1) / 2;
  localparam int PADW  = 2 * NCELL;

  logic [PADW-1:0]  xp;
  logic [PADW-1:0]  yp;
  rel_t [NCELL-1:0] leaf;
  rel_t             root;

  assign xp = PADW'(x_in);
  assign yp = PADW'(y_in);

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    mag_cmp_cell2 u_cell (
      .a   (xp[2*c +: 2]),
      .b   (yp[2*c +: 2]),
      .rel (leaf[c])
    );
  end

  if (USE_TREE) begin : g_tree
    mag_cmp_tree #(.NCELL(NCELL)) u_merge (
      .leaf (leaf),
      .root (root)
    );
  end else begin : g_chain
    mag_cmp_chain #(.NCELL(NCELL)) u_merge (
      .leaf (leaf),
      .root (root)
    );
  end

  assign gt_o = root.gt;
  assign lt_o = root.lt;

endmodule

// File: tb/mag_cmp_tb_top.sv
module mag_cmp_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] a8, b8;
  logic [4:0] a5, b5;
  logic gt_t, lt_t, gt_c, lt_c, gt_5, lt_5;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  mag_cmp #(.WIDTH(8), .USE_TREE(1'b1)) dut_i (
    .x_in(a8), .y_in(b8), .gt_o(gt_t), .lt_o(lt_t));
  mag_cmp #(.WIDTH(8), .USE_TREE(1'b0)) dut_chain_i (
    .x_in(a8), .y_in(b8), .gt_o(gt_c), .lt_o(lt_c));
  mag_cmp #(.WIDTH(5), .USE_TREE(1'b1)) dut_odd_i (
    .x_in(a5), .y_in(b5), .gt_o(gt_5), .lt_o(lt_5));

  // {x, y, gt, lt}
  localparam logic [17:0] VEC [16] = '{
    {8'h00, 8'h00, 2'b00}, {8'hFF, 8'hFF, 2'b00}, {8'hFF, 8'h00, 2'b10},
    {8'h00, 8'hFF, 2'b01}, {8'h80, 8'h7F, 2'b10}, {8'h7F, 8'h80, 2'b01},
    {8'h01, 8'h00, 2'b10}, {8'h00, 8'h01, 2'b01}, {8'hA5, 8'hA4, 2'b10},
    {8'h5A, 8'h5B, 2'b01}, {8'hC3, 8'hC3, 2'b00}, {8'h40, 8'h3F, 2'b10},
    {8'h12, 8'h21, 2'b01}, {8'hF0, 8'h0F, 2'b10}, {8'hAA, 8'h55, 2'b10},
    {8'h55, 8'hAA, 2'b01}
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b (x=%h y=%h)", req, act, exp, a8, b8);
    end
  endtask

  task automatic apply8(input logic [7:0] x, input logic [7:0] y);
    @(posedge clk);
    a8 = x;
    b8 = y;
    @(negedge clk);
  endtask

  initial begin
    a8 = '0; b8 = '0; a5 = '0; b5 = '0;
    @(negedge clk);
    chk("R3 zero operands", {gt_t, lt_t}, 2'b00);

    for (int i = 0; i < 16; i++) begin
      apply8(VEC[i][17:10], VEC[i][9:2]);
      chk(VEC[i][1:0] == 2'b00 ? "R3 table" : (VEC[i][1] ? "R1 table" : "R2 table"),
          {gt_t, lt_t}, VEC[i][1:0]);
      chk("R7 table chain", {gt_c, lt_c}, VEC[i][1:0]);
    end

    apply8(8'h80, 8'h7F); chk("R5 high slice wins gt", {gt_t, lt_t}, 2'b10);
    apply8(8'h7F, 8'h80); chk("R5 high slice wins lt", {gt_c, lt_c}, 2'b01);
    apply8(8'h51, 8'h50); chk("R6 low slice decides gt", {gt_t, lt_t}, 2'b10);
    apply8(8'h50, 8'h51); chk("R6 low slice decides lt", {gt_c, lt_c}, 2'b01);

    // R9: outputs follow an input change with no clock edge in between.
    @(negedge clk);
    a8 = 8'h03; b8 = 8'h02;
    #1;
    chk("R9 same-cycle gt", {gt_t, lt_t}, 2'b10);
    b8 = 8'h04;
    #1;
    chk("R9 same-cycle lt", {gt_t, lt_t}, 2'b01);

    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        apply8(8'(x), 8'(y));
        chk("R1 exhaustive gt", {1'b0, gt_t}, {1'b0, x > y});
        chk("R2 exhaustive lt", {1'b0, lt_t}, {1'b0, x < y});
        chk("R4 exclusive", {1'b0, gt_t & lt_t}, 2'b00);
        chk("R7 chain matches tree", {gt_c, lt_c}, {gt_t, lt_t});
      end
    end

    for (int x = 0; x < 32; x++) begin
      for (int y = 0; y < 32; y++) begin
        @(posedge clk);
        a5 = 5'(x);
        b5 = 5'(y);
        @(negedge clk);
        chk("R8 odd width", {gt_5, lt_5}, {x > y, x < y});
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule